// File: doc/BRIEF.md
# Fractional Clock-Enable Generator with Kick Handshake

This block produces a clock-enable qualifier at a programmable fraction of its parent clock, from 1/32 up to 32/32 of the parent rate. Logic downstream that runs on the same parent clock and is qualified by the enable then advances at the chosen rate. The output is a qualifier only. It is never used as a gated clock.

Software programs a 5-bit rate field in a control register. The field holds 32 minus the wanted multiplier, so a field value of 0 means full rate. The new setting does nothing until software sets a kick bit in a second register. The block then takes the shadow field into its active multiplier at the next 32-cycle window boundary. One cycle later the block clears the kick bit, and software polls for that. While the kick bit is set, writes to the control register are dropped.

Inside each 32-cycle window, a phase accumulator adds the multiplier modulo 32 and raises the enable on every carry. This spreads the pulses evenly across the window.

Top module: `frac_clk_en`

## Requirements
- R1: After reset the control register reads 0, the kick bit reads 0, and the enable is high on every cycle.
- R2: With a rate field value f active, any 32 consecutive cycles contain exactly 32-f enable pulses.
- R3: The control register is at address 0 and its rate field is bits 12:8. All 32 bits are stored and read back unchanged, so a read-modify-write keeps the bits outside the field.
- R4: Writing a new rate field does not change the enable rate until a kick is applied.
- R5: The kick register is at address 1. Writing it with bit 31 set sets the kick bit, which reads back at bit 31 of address 1 while the change is pending. The other bits of that register read 0. Writing it with bit 31 clear has no effect.
- R6: Counting clock edges after reset release from 1, the active multiplier loads at edges numbered 32k. The kick bit is still 1 after the first such edge that follows the kick write, and reads 0 after the next edge.
- R7: Writes to the control register while the kick bit is 1 are ignored, and the register keeps its previous contents.
- R8: Field value 31 gives one pulse per 32 cycles, and field value 0 gives a pulse on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 is the control register, 1 is the kick register |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| clk_en_o | output | 1 | Clock-enable qualifier |

## Verification
The hardest situation to reach is the exact cycle in which the kick bit clears, because the window phase is internal and cannot be seen. The bench counts clock edges from reset release, computes the first window boundary after each kick write, and reads the kick bit through the read port on both sides of the clear. It then attempts a control-register write during that busy interval and reads the register back. It also sweeps every field value and counts pulses over 64 cycles.

// File: rtl/frac_clk_en.sv
module frac_clk_en #(
  parameter int WIN_W     = 5,
  parameter int FIELD_LSB = 8,
  parameter int KICK_BIT  = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_we,
  output logic [31:0] reg_rdata,
  output logic        clk_en_o
);
  localparam int WIN = 1 << WIN_W;
  localparam logic [WIN_W:0] FULL = WIN_W'(0) + (WIN_W+1)'(WIN);

  logic [31:0]      ctrl_q;
  logic             kick_q;
  logic [WIN_W-1:0] phase_q;
  logic [WIN_W-1:0] acc_q;
  logic [WIN_W:0]   mult_q;
  logic [WIN_W:0]   sum;
  logic             boundary;
  logic [WIN_W-1:0] field;

  assign field    = ctrl_q[FIELD_LSB +: WIN_W];
  assign boundary = (phase_q == {WIN_W{1'b1}});
  assign sum      = {1'b0, acc_q} + mult_q;
  assign clk_en_o = sum[WIN_W];
  assign reg_rdata = reg_addr ? {kick_q, 31'b0} : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      kick_q  <= 1'b0;
      phase_q <= '0;
      acc_q   <= '0;
      mult_q  <= FULL;
    end else begin
      phase_q <= phase_q + 1'b1;
      acc_q   <= sum[WIN_W-1:0];
      if (reg_we && !reg_addr && !kick_q)
        ctrl_q <= reg_wdata;
      if (reg_we && reg_addr && reg_wdata[KICK_BIT])
        kick_q <= 1'b1;
      if (kick_q && boundary)
        mult_q <= FULL - {1'b0, field};
      if (kick_q && phase_q == '0 && mult_q == FULL - {1'b0, field})
        kick_q <= 1'b0;
    end
  end

  always_comb begin
    if (rst_n) assert (mult_q >= 1 && mult_q <= FULL);
  end

  p_kick_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kick_q) |-> $past(phase_q) == '0);

  p_mult_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(mult_q));

  p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_q && reg_we && !reg_addr) |=> $stable(ctrl_q));

  p_acc_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> acc_q == '0);
endmodule

// File: tb/test_frac_clk_en.sv
module test_frac_clk_en;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic        reg_we = 0;
  logic [31:0] reg_rdata;
  logic        clk_en_o;

  int checks = 0, fails = 0;
  int ecount = 0, pcount = 0;

  frac_clk_en i_frac_clk_en (.*);

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) begin
    ecount <= ecount + 1;
    if (clk_en_o) pcount <= pcount + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulses64(output int n);
    int p0;
    p0 = pcount;
    repeat (64) @(negedge clk);
    n = pcount - p0;
  endtask

  task automatic kick_and_time(input string req);
    int ew, b;
    logic [31:0] d;
    ew = ecount + 1;
    b = (ew / 32 + 1) * 32;
    wr(1, 32'h8000_0000);
    rd(1, d); chk(req, d, 32'h8000_0000);
    while (ecount < b) @(negedge clk);
    rd(1, d); chk(req, d, 32'h8000_0000);
    @(negedge clk);
    rd(1, d); chk(req, d, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d; int n;
    rd(0, d); chk("R1", d, 0);
    rd(1, d); chk("R1", d, 0);
    pulses64(n); chk("R1", n, 64);
  endtask

  task automatic t_field_rw;
    logic [31:0] d; int n;
    wr(0, 32'hA5A5_E3C3);
    rd(0, d); chk("R3", d, 32'hA5A5_E3C3);
    pulses64(n); chk("R4", n, 64);
    wr(1, 32'h7FFF_FFFF);
    rd(1, d); chk("R5", d, 0);
    pulses64(n); chk("R4", n, 64);
    kick_and_time("R6");
    pulses64(n); chk("R2", n, 2 * (32 - 5'h03));
    rd(0, d);
    d[12:8] = 5'd10;
    wr(0, d);
    rd(0, d); chk("R3", d, 32'hA5A5_EAC3);
  endtask

  task automatic t_busy;
    logic [31:0] d; int n;
    wr(1, 32'h8000_0000);
    wr(0, 32'h0000_1F00);
    rd(0, d); chk("R7", d, 32'hA5A5_EAC3);
    while (d[31]) begin @(negedge clk); rd(1, d); end
    pulses64(n); chk("R7", n, 2 * 22);
  endtask

  task automatic t_sweep;
    logic [31:0] d; int n;
    for (int f = 0; f < 32; f++) begin
      wr(0, f << 8);
      kick_and_time("R6");
      pulses64(n);
      if (f == 31 || f == 0) chk("R8", n, 2 * (32 - f));
      else chk("R2", n, 2 * (32 - f));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_field_rw;
    t_busy;
    t_sweep;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule